// File: doc/BRIEF.md
# Multi-Mode DMA Channel Sequencer

This block is one DMA channel. It copies a number of words from a source address to a destination address and counts a transfer counter down to zero. Software programs a source address, a destination address and a count. It then writes a control word that holds a run flag, a three-bit trigger mode, a block-request flag and a burst flag. A second write location changes only the run flag, so the channel can be started or halted without rewriting the rest of the control word.

The trigger mode sets when a transfer unit may begin:
- **Free-running:** units start whenever the channel is running.
- **External request:** units wait for an external request on a request/acknowledge pair.
- **Serial transmit, serial receive, cipher input, cipher output:** the same pair paces the channel against a peripheral. The peripheral side is a fixed address on the memory port.

In **single** request mode, every unit consumes one request. In **block** mode, one request drives the whole count. In **burst** mode, a unit reads up to four words into a local buffer and then writes them out. The last group is shortened when the count is not a multiple of four.

When the count reaches zero, the channel drops its run flag and raises a one-cycle completion pulse. The memory side uses a single word-wide port with a request/ready handshake.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, the control word reads 0, the count reads 0, and `done_o`, `ack_o` and `mem_req_o` are low.
- R2: Register selects on `cfg_sel`:
  - 0 writes the whole control word. Bit 0 is run, bits [3:1] are the mode, bit 4 is block, bit 5 is burst.
  - 1 writes only bit 0 from `cfg_wdata[0]`, leaving bits [5:1] unchanged.
  - 2 writes the source address, 3 the destination address and 4 the count. These three take effect only while no transfer unit is in progress.
- R3: In mode 000 the channel needs no request. It reads a word at the source, then writes it at the destination. Both addresses advance by DATA_W/8 per word.
- R4: In the request modes (001 to 101) without block operation, no memory access happens until `req_i` is seen. Each unit consumes one request, and `ack_o` pulses for one cycle right after the unit's last write.
- R5: With bit 4 set and mode 001, a single request drives transfers until the count reaches zero, and `ack_o` pulses once at the end. Bit 4 has no effect in the other modes.
- R6: With bit 5 set in modes 000, 001, 100 or 101, a unit reads up to four consecutive words and then writes them to consecutive destinations in the same order.
- R7: In burst operation the unit length is the smaller of four and the remaining count, so a count of 6 gives a unit of 4 and then a unit of 2.
- R8: In modes 010 and 011, bit 5 is ignored and every unit is one word.
- R9: The peripheral side stays at a fixed address:
  - The destination stays fixed in modes 010 and 100.
  - The source stays fixed in modes 011 and 101.
- R10: When the count reaches zero, the run bit clears and `done_o` pulses for one cycle. Starting with a count of zero gives the pulse with no memory access.
- R11: Clearing run during a unit lets that unit finish. No further access follows, the count keeps the remaining value, and there is no done pulse.
- R12: Mode codes 110 and 111 produce no memory access and leave run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| ctrl_o | output | 6 | Current control word |
| cnt_o | output | CNT_W | Remaining transfer count |
| done_o | output | 1 | One-cycle completion pulse |
| req_i | input | 1 | Transfer request from external source or peripheral |
| ack_o | output | 1 | One-cycle acknowledge of a served request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts the current access |

## Verification
Errors in the internal state show up at the ports in distinct ways:
- **Beat counter or unit-length register:** a wrong value changes the order of reads and writes on the memory port within one unit, and puts an extra or missing access at a group boundary.
- **Address registers:** the next accepted access carries a wrong address, or a fixed peripheral address moves.
- **Trigger state:** a wrong armed flag or request gate shows up as an access without a request, or as a stall while a request is held.
- **Count or finish logic:** becomes visible one cycle after the final write, through `done_o`, the run bit and `cnt_o`.

Each of these shows up no later than the first unit after the fault.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam logic [2:0] MODE_SW   = 3'b000;
    localparam logic [2:0] MODE_EXT  = 3'b001;
    localparam logic [2:0] MODE_STX  = 3'b010;
    localparam logic [2:0] MODE_SRX  = 3'b011;
    localparam logic [2:0] MODE_CIN  = 3'b100;
    localparam logic [2:0] MODE_COUT = 3'b101;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_RUN  = 3'd1;
    localparam logic [2:0] SEL_SRC  = 3'd2;
    localparam logic [2:0] SEL_DST  = 3'd3;
    localparam logic [2:0] SEL_CNT  = 3'd4;

    typedef struct packed {
        logic       burst;
        logic       blk;
        logic [2:0] mode;
        logic       run;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_e;

    function automatic logic mode_ok(input logic [2:0] m);
        return m <= MODE_COUT;
    endfunction

    function automatic logic burst_allowed(input logic [2:0] m);
        return (m == MODE_SW) || (m == MODE_EXT) || (m == MODE_CIN) || (m == MODE_COUT);
    endfunction

    function automatic logic src_pinned(input logic [2:0] m);
        return (m == MODE_SRX) || (m == MODE_COUT);
    endfunction

    function automatic logic dst_pinned(input logic [2:0] m);
        return (m == MODE_STX) || (m == MODE_CIN);
    endfunction

endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [5:0] wr_data,
    input  logic       hw_clr_run,
    output ctrl_t      ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl_d = ctrl_t'(wr_data);
        end else if (wr_en && wr_sel == SEL_RUN) begin
            ctrl_d.run = wr_data[0];
        end
        if (hw_clr_run) begin
            ctrl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    // R2: run-only write leaves the mode, block and burst fields untouched
    p_alias_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RUN) |=> (ctrl_q[5:1] == $past(ctrl_q[5:1])));

    // R10: completion clears the run flag on the next edge
    p_hw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_run |=> !ctrl_q.run);

endmodule

// File: rtl/dma_trigger.sv
module dma_trigger
    import dma_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_i,
    input  logic  idle_i,
    input  logic  unit_start_i,
    input  logic  unit_end_i,
    input  logic  last_unit_i,
    input  logic  req_i,
    output logic  permit_o,
    output logic  ack_o
);

    typedef struct packed {
        logic armed;
        logic ack;
    } trig_t;

    trig_t t_d, t_q;
    logic  block_en;
    logic  free_run;
    logic  unused_ctrl;

    assign unused_ctrl = ctrl_i.burst;
    assign block_en    = ctrl_i.blk && (ctrl_i.mode == MODE_EXT);
    assign free_run    = (ctrl_i.mode == MODE_SW);

    always_comb begin
        t_d     = t_q;
        t_d.ack = unit_end_i && !free_run && (!block_en || last_unit_i);
        if (unit_start_i && block_en) begin
            t_d.armed = 1'b1;
        end
        if ((idle_i && !ctrl_i.run) || (unit_end_i && last_unit_i)) begin
            t_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign permit_o = free_run || t_q.armed || (req_i && !t_q.ack);
    assign ack_o    = t_q.ack;

    // R4: acknowledge is a single-cycle pulse
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.ack |=> !t_q.ack);

    // R5: the block latch never survives a stopped, idle channel
    p_armed_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !ctrl_i.run) |=> !t_q.armed);

endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [DATA_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_idx == IDX_W'(gi)) ent_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign slot[gi] = ent_q;
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [5:0]        ctrl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              done_o,
    input  logic              req_i,
    output logic              ack_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i
);

    localparam int STEP   = DATA_W / 8;
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int LEN_W  = BEAT_W + 1;

    typedef struct packed {
        seq_st_e            st;
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  dst;
        logic [CNT_W-1:0]   cnt;
        logic [BEAT_W-1:0]  beat;
        logic [LEN_W-1:0]   len;
        logic               src_fix;
        logic               dst_fix;
        logic               done;
    } seq_t;

    seq_t  s_d, s_q;
    ctrl_t ctrl;
    logic  clr_run, unit_start, unit_end, last_unit, buf_we;
    logic  permit, xfer, addr_wr, last_beat, use_burst;
    logic  [DATA_W-1:0] buf_rd;
    logic  unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    dma_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata[5:0]),
        .hw_clr_run (clr_run),
        .ctrl_o     (ctrl)
    );

    dma_trigger u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_i       (ctrl),
        .idle_i       (s_q.st == ST_IDLE),
        .unit_start_i (unit_start),
        .unit_end_i   (unit_end),
        .last_unit_i  (last_unit),
        .req_i        (req_i),
        .permit_o     (permit),
        .ack_o        (ack_o)
    );

    dma_burst_buf #(.DATA_W(DATA_W), .DEPTH(BURST_LEN)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (s_q.beat),
        .wr_data (mem_rdata_i),
        .rd_idx  (s_q.beat),
        .rd_data (buf_rd)
    );

    assign xfer      = mem_req_o && mem_ready_i;
    assign addr_wr   = cfg_we && (cfg_sel == SEL_SRC || cfg_sel == SEL_DST || cfg_sel == SEL_CNT);
    assign last_beat = ({1'b0, s_q.beat} == (s_q.len - LEN_W'(1)));
    assign use_burst = ctrl.burst && burst_allowed(ctrl.mode);

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        clr_run    = 1'b0;
        unit_start = 1'b0;
        unit_end   = 1'b0;
        last_unit  = 1'b0;
        buf_we     = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (addr_wr) begin
                    if (cfg_sel == SEL_SRC) s_d.src = cfg_wdata[ADDR_W-1:0];
                    if (cfg_sel == SEL_DST) s_d.dst = cfg_wdata[ADDR_W-1:0];
                    if (cfg_sel == SEL_CNT) s_d.cnt = cfg_wdata[CNT_W-1:0];
                end else if (ctrl.run && mode_ok(ctrl.mode)) begin
                    if (s_q.cnt == '0) begin
                        clr_run  = 1'b1;
                        s_d.done = 1'b1;
                    end else if (permit) begin
                        unit_start  = 1'b1;
                        s_d.st      = ST_RD;
                        s_d.beat    = '0;
                        s_d.src_fix = src_pinned(ctrl.mode);
                        s_d.dst_fix = dst_pinned(ctrl.mode);
                        if (!use_burst)                          s_d.len = LEN_W'(1);
                        else if (s_q.cnt < CNT_W'(BURST_LEN))    s_d.len = LEN_W'(s_q.cnt);
                        else                                     s_d.len = LEN_W'(BURST_LEN);
                    end
                end
            end
            ST_RD: begin
                if (xfer) begin
                    buf_we = 1'b1;
                    if (!s_q.src_fix) s_d.src = s_q.src + ADDR_W'(STEP);
                    if (last_beat) begin
                        s_d.beat = '0;
                        s_d.st   = ST_WR;
                    end else begin
                        s_d.beat = s_q.beat + BEAT_W'(1);
                    end
                end
            end
            ST_WR: begin
                if (xfer) begin
                    if (!s_q.dst_fix) s_d.dst = s_q.dst + ADDR_W'(STEP);
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                    if (last_beat) begin
                        unit_end = 1'b1;
                        s_d.beat = '0;
                        s_d.st   = ST_IDLE;
                        if (s_q.cnt == CNT_W'(1)) begin
                            last_unit = 1'b1;
                            clr_run   = 1'b1;
                            s_d.done  = 1'b1;
                        end
                    end else begin
                        s_d.beat = s_q.beat + BEAT_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign ctrl_o      = ctrl;
    assign cnt_o       = s_q.cnt;
    assign done_o      = s_q.done;
    assign mem_req_o   = (s_q.st != ST_IDLE);
    assign mem_we_o    = (s_q.st == ST_WR);
    assign mem_addr_o  = (s_q.st == ST_WR) ? s_q.dst : s_q.src;
    assign mem_wdata_o = buf_rd;

    // R3: a stalled access keeps its address and direction
    p_hold_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R10: the done pulse is one cycle and comes with run already low
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ctrl_o[0]);

    // R12: reserved modes keep the sequencer idle
    p_reserved_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !mode_ok(ctrl.mode)) |=> !mem_req_o);

    // R7: a unit's beat index stays inside its length, which never exceeds the burst size
    p_beat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (s_q.len != '0 && s_q.len <= LEN_W'(BURST_LEN) && {1'b0, s_q.beat} < s_q.len));

    // R9: a pinned peripheral source does not move on an accepted read
    p_src_pinned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RD && s_q.src_fix && xfer) |=> $stable(s_q.src));

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  ctrl_o;
    logic [15:0] cnt_o;
    logic        done_o, ack_o, req = 1'b0;
    logic        mem_req, mem_we, mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        stall_en = 1'b0;

    int n_chk = 0, n_bad = 0;
    int log_n = 0, ack_n = 0, done_n = 0, cyc = 0;
    logic        log_we [256];
    logic [31:0] log_addr [256];
    logic [31:0] log_wd [256];

    always #(CLK_P/2) clk = ~clk;

    dma_chan_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ctrl_o(ctrl_o), .cnt_o(cnt_o), .done_o(done_o), .req_i(req), .ack_o(ack_o),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'hC0DE_0000 | {16'h0, a[15:0]};
    endfunction

    assign mem_rdata = pat(mem_addr);

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready && log_n < 256) begin
            log_we[log_n]   <= mem_we;
            log_addr[log_n] <= mem_addr;
            log_wd[log_n]   <= mem_wdata;
            log_n           <= log_n + 1;
        end
        if (rst_n && ack_o)  ack_n  <= ack_n + 1;
        if (rst_n && done_o) done_n <= done_n + 1;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= stall_en ? ((cyc % 3) != 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        cfg_wr(3'd2, s); cfg_wr(3'd3, d); cfg_wr(3'd4, c);
    endtask

    task automatic wait_done(input int d0, input string tag);
        int t = 0;
        while (done_n == d0 && t < 2000) begin @(negedge clk); t++; end
        chk(done_n == d0 + 1, tag, done_n - d0, 1);
    endtask

    task automatic serve_req(input string tag);
        int t = 0;
        @(negedge clk); req = 1'b1;
        @(negedge clk);
        while (!ack_o && t < 500) begin @(negedge clk); t++; end
        req = 1'b0;
        chk(t < 500, tag, t, 0);
    endtask

    task automatic check_seq(input int mark, input int cnt, input bit burst,
                             input logic [31:0] s0, input logic [31:0] d0,
                             input bit sfix, input bit dfix, input string tag);
        int idx = mark;
        int rem = cnt;
        int n;
        logic [31:0] s = s0;
        logic [31:0] d = d0;
        logic [31:0] sa [4];
        chk(log_n - mark == 2 * cnt, {tag, " access count"}, log_n - mark, 2 * cnt);
        if (log_n - mark != 2 * cnt) return;
        while (rem > 0) begin
            n = burst ? ((rem < 4) ? rem : 4) : 1;
            for (int j = 0; j < n; j++) begin
                chk(!log_we[idx] && log_addr[idx] == s, {tag, " read"}, {log_we[idx], log_addr[idx]}, {1'b0, s});
                sa[j] = s;
                if (!sfix) s = s + 4;
                idx++;
            end
            for (int j = 0; j < n; j++) begin
                chk(log_we[idx] && log_addr[idx] == d && log_wd[idx] == pat(sa[j]), {tag, " write"},
                    {log_addr[idx], log_wd[idx]}, {d, pat(sa[j])});
                if (!dfix) d = d + 4;
                idx++;
            end
            rem -= n;
        end
    endtask

    task automatic t_reset();
        chk(ctrl_o == 6'h0 && cnt_o == 16'h0, "R1 regs", {ctrl_o, cnt_o}, 0);
        chk(!done_o && !ack_o && !mem_req, "R1 outputs", {done_o, ack_o, mem_req}, 0);
    endtask

    task automatic t_cfg_reserved();
        int mark;
        cfg_wr(3'd0, 32'h3C);
        chk(ctrl_o == 6'h3C, "R2 full write", ctrl_o, 6'h3C);
        mark = log_n;
        cfg_wr(3'd1, 32'hFFFF_FFC1);
        chk(ctrl_o == 6'h3D, "R2 alias set keeps fields", ctrl_o, 6'h3D);
        repeat (10) @(negedge clk);
        chk(log_n == mark, "R12 reserved no access", log_n - mark, 0);
        chk(ctrl_o[0] == 1'b1, "R12 run stays set", ctrl_o[0], 1);
        cfg_wr(3'd1, 32'h0000_003E);
        chk(ctrl_o == 6'h3C, "R2 alias clear keeps fields", ctrl_o, 6'h3C);
    endtask

    task automatic t_sw();
        int mark, d0;
        setup(32'h00, 32'h80, 3);
        mark = log_n; d0 = done_n;
        cfg_wr(3'd0, 32'h01);
        wait_done(d0, "R10 sw done");
        check_seq(mark, 3, 1'b0, 32'h00, 32'h80, 1'b0, 1'b0, "R3 sw copy");
        chk(ctrl_o == 6'h00 && cnt_o == 0, "R10 run cleared", {ctrl_o, cnt_o}, 0);
    endtask

    task automatic t_zero();
        int mark, d0;
        setup(32'h00, 32'h80, 0);
        mark = log_n; d0 = done_n;
        cfg_wr(3'd0, 32'h01);
        wait_done(d0, "R10 zero count done");
        chk(log_n == mark, "R10 zero count no access", log_n - mark, 0);
        chk(ctrl_o[0] == 1'b0, "R10 zero count run cleared", ctrl_o[0], 0);
    endtask

    task automatic t_burst();
        int mark, d0;
        stall_en = 1'b1;
        setup(32'h10, 32'hA0, 6);
        mark = log_n; d0 = done_n;
        cfg_wr(3'd0, 32'h21);
        wait_done(d0, "R7 burst done");
        check_seq(mark, 6, 1'b1, 32'h10, 32'hA0, 1'b0, 1'b0, "R6 R7 burst groups");
        stall_en = 1'b0;
    endtask

    task automatic t_single();
        int mark, d0, a0;
        setup(32'h30, 32'hD0, 2);
        mark = log_n; d0 = done_n; a0 = ack_n;
        cfg_wr(3'd0, 32'h03);
        repeat (8) @(negedge clk);
        chk(log_n == mark, "R4 waits for request", log_n - mark, 0);
        serve_req("R4 first request");
        chk(log_n - mark == 2 && cnt_o == 1, "R4 one unit per request", {log_n - mark, cnt_o}, {32'd2, 16'd1});
        serve_req("R4 second request");
        wait_done(d0, "R4 done");
        check_seq(mark, 2, 1'b0, 32'h30, 32'hD0, 1'b0, 1'b0, "R4 single copy");
        chk(ack_n - a0 == 2, "R4 ack per unit", ack_n - a0, 2);
    endtask

    task automatic t_block();
        int mark, d0, a0;
        setup(32'h40, 32'hE0, 3);
        mark = log_n; d0 = done_n; a0 = ack_n;
        cfg_wr(3'd0, 32'h13);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        wait_done(d0, "R5 block done");
        check_seq(mark, 3, 1'b0, 32'h40, 32'hE0, 1'b0, 1'b0, "R5 block copy");
        chk(ack_n - a0 == 1, "R5 one ack", ack_n - a0, 1);
        chk(ctrl_o == 6'h12, "R5 run cleared", ctrl_o, 6'h12);
    endtask

    task automatic t_tx();
        int mark, d0, a0;
        setup(32'h50, 32'hF0, 3);
        mark = log_n; d0 = done_n; a0 = ack_n;
        cfg_wr(3'd0, 32'h35);
        for (int k = 0; k < 3; k++) serve_req("R8 tx request");
        wait_done(d0, "R8 tx done");
        check_seq(mark, 3, 1'b0, 32'h50, 32'hF0, 1'b0, 1'b1, "R8 R9 tx single words");
        chk(ack_n - a0 == 3, "R5 block bit ignored in tx", ack_n - a0, 3);
    endtask

    task automatic t_rx();
        int mark, d0;
        setup(32'hF4, 32'h60, 2);
        mark = log_n; d0 = done_n;
        cfg_wr(3'd0, 32'h07);
        for (int k = 0; k < 2; k++) serve_req("R9 rx request");
        wait_done(d0, "R9 rx done");
        check_seq(mark, 2, 1'b0, 32'hF4, 32'h60, 1'b1, 1'b0, "R9 rx fixed source");
    endtask

    task automatic t_cout();
        int mark, d0, a0;
        setup(32'hF8, 32'h70, 5);
        mark = log_n; d0 = done_n; a0 = ack_n;
        cfg_wr(3'd0, 32'h2B);
        for (int k = 0; k < 2; k++) serve_req("R6 cipher request");
        wait_done(d0, "R7 cipher done");
        check_seq(mark, 5, 1'b1, 32'hF8, 32'h70, 1'b1, 1'b0, "R6 R7 R9 cipher burst");
        chk(ack_n - a0 == 2, "R6 ack per burst", ack_n - a0, 2);
    endtask

    task automatic t_stop();
        int mark, d0, t;
        setup(32'h00, 32'h80, 10);
        mark = log_n; d0 = done_n; t = 0;
        cfg_wr(3'd0, 32'h21);
        while (log_n == mark && t < 100) begin @(negedge clk); t++; end
        cfg_wr(3'd1, 32'h0);
        repeat (20) @(negedge clk);
        chk(log_n - mark == 8, "R11 current burst finishes", log_n - mark, 8);
        chk(cnt_o == 6, "R11 count kept", cnt_o, 6);
        chk(done_n == d0, "R11 no done", done_n - d0, 0);
        chk(ctrl_o == 6'h20, "R11 run low", ctrl_o, 6'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_reserved();
        t_sw();
        t_zero();
        t_burst();
        t_single();
        t_block();
        t_tx();
        t_rx();
        t_cout();
        t_stop();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule